// File: doc/BRIEF.md
# Composite Sync and Blanking Generator

This block turns the raw horizontal and vertical sync pulses of a CRT controller into the signals a monitor needs: a composite sync and a forced-black blanking flag. Whatever width the controller programs for its sync pulses, the block reshapes them into fixed windows. It counts character clocks while horizontal sync is high and emits a shortened horizontal sync. It counts lines after vertical sync starts and emits a fixed-length vertical sync. It holds the picture black for a fixed run of lines. The two shaped syncs are merged by XNOR into one active-low composite sync.

The block also pulses a strobe when the horizontal count reaches its switch-on point. The pixel path uses that strobe to latch a pending graphics-mode change. The character clock arrives as a one-cycle enable in the system clock domain. All inputs are sampled only on that enable.

Top module: `csb_gen`

## Requirements
- R1: After synchronous reset, with both raw syncs low, `blank` is 0, `csync_n` is 1, `mode_strobe` is 0 and both shaped syncs are 0.
- R2: The horizontal count goes up by one on each `char_en` with `hsync_in` high, saturating at HS_OFF (6). It returns to 0 on any `char_en` with `hsync_in` low.
- R3: `hsync_out` is high while `hsync_in` is high and the horizontal count is at least HS_ON (2) and below HS_OFF (6). A raw pulse of W characters gives max(0, min(W,6)-2) characters of shaped sync, and a raw pulse that ends early cuts the shaped sync short.
- R4: `mode_strobe` is a single system-clock pulse, in the cycle after the `char_en` on which the horizontal count becomes 2. A raw pulse shorter than 2 characters gives no strobe.
- R5: `blank` is 1 in every cycle in which `hsync_in` is 1.
- R6: A rising edge of `vsync_in`, sampled on `char_en`, clears the line count and starts the vertical window. Each end of horizontal sync (a `char_en` with `hsync_in` low after a nonzero horizontal count) advances the line count. `vsync_out` is high while the line count is 2 to 5.
- R7: `blank` stays 1 from the vertical start until the 26th end of horizontal sync after it, however short or long `vsync_in` is.
- R8: A new rising edge of `vsync_in` during the 26-line window restarts the line count from 0. If it falls on the same `char_en` as an end of horizontal sync, the restart wins.
- R9: `csync_n` is the XNOR of `hsync_out` and `vsync_out`. It is 0 when exactly one of them is high and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| char_en | input | 1 | One-cycle character clock enable |
| hsync_in | input | 1 | Raw horizontal sync from the CRT controller, active high |
| vsync_in | input | 1 | Raw vertical sync from the CRT controller, active high |
| blank | output | 1 | Force-black flag |
| csync_n | output | 1 | Composite sync, active low |
| mode_strobe | output | 1 | Pulse that applies a pending graphics-mode change |
| hsync_out | output | 1 | Shaped horizontal sync, active high |
| vsync_out | output | 1 | Shaped vertical sync, active high |

## Verification
Directed lines use raw horizontal pulse widths of 0, 1, 2, 5, 6 and 14 characters. These separate a missing strobe, a shortened sync and a saturated, cut-off window. Vertical tests include a one-line pulse and a pulse longer than the blanking window. These show that blanking length does not depend on raw width. A second edge inside the window shows the restart. Random lines with random pulse positions and widths, and random vertical pulses, are then compared cycle by cycle against a bench model. This exercises overlap of the two shaped syncs, where the XNOR returns the composite line high.

// File: rtl/csb_pkg.sv
package csb_pkg;

    // default window edges, in character clocks and in lines
    localparam int unsigned HS_ON_DEF   = 2;
    localparam int unsigned HS_OFF_DEF  = 6;
    localparam int unsigned VS_ON_DEF   = 2;
    localparam int unsigned VS_OFF_DEF  = 6;
    localparam int unsigned VBLANK_DEF  = 26;

    typedef struct packed {
        logic hs;
        logic vs;
    } sync_pair_t;

    // true when on <= cnt < off
    function automatic logic in_window(int unsigned cnt, int unsigned on, int unsigned off);
        return (cnt >= on) && (cnt < off);
    endfunction

    // XNOR merge of two active-high syncs into an active-low composite
    function automatic logic merge_sync(sync_pair_t s);
        return ~(s.hs ^ s.vs);
    endfunction

endpackage

// File: rtl/csb_hcount.sv
module csb_hcount
    import csb_pkg::*;
#(
    parameter int unsigned HS_ON  = HS_ON_DEF,
    parameter int unsigned HS_OFF = HS_OFF_DEF,
    localparam int unsigned HW    = $clog2(HS_OFF + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic char_en,
    input  logic hsync_in,
    output logic hsync_out,
    output logic mode_strobe,
    output logic hs_end
);

    logic [HW-1:0] hcnt;
    logic          strobe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hcnt     <= '0;
            strobe_q <= 1'b0;
        end else begin
            strobe_q <= 1'b0;
            if (char_en) begin
                if (hsync_in) begin
                    if (hcnt != HW'(HS_OFF))
                        hcnt <= hcnt + 1'b1;
                    strobe_q <= (hcnt == HW'(HS_ON - 1));
                end else begin
                    hcnt <= '0;
                end
            end
        end
    end

    assign hs_end      = char_en && !hsync_in && (hcnt != '0);
    assign hsync_out   = hsync_in && in_window(32'(hcnt), HS_ON, HS_OFF);
    assign mode_strobe = strobe_q;

    assert_strobe_at_on_R4: assert property (@(posedge clk) disable iff (rst)
        mode_strobe |-> (hcnt == HW'(HS_ON)));
    assert_hcnt_clears_R2: assert property (@(posedge clk) disable iff (rst)
        (char_en && !hsync_in) |=> (hcnt == '0));
    assert_hcnt_bounded_R2: assert property (@(posedge clk) disable iff (rst)
        hcnt <= HW'(HS_OFF));
    assert_strobe_single_R4: assert property (@(posedge clk) disable iff (rst)
        mode_strobe |=> !mode_strobe);

endmodule

// File: rtl/csb_vcount.sv
module csb_vcount
    import csb_pkg::*;
#(
    parameter int unsigned VS_ON  = VS_ON_DEF,
    parameter int unsigned VS_OFF = VS_OFF_DEF,
    parameter int unsigned LINES  = VBLANK_DEF,
    localparam int unsigned VW    = $clog2(LINES + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic char_en,
    input  logic vsync_in,
    input  logic hs_end,
    output logic vsync_out,
    output logic vblank
);

    logic [VW-1:0] vcnt;
    logic          vact;
    logic          vs_q;
    logic          vs_rise;

    assign vs_rise = char_en && vsync_in && !vs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vcnt <= '0;
            vact <= 1'b0;
            vs_q <= 1'b0;
        end else if (char_en) begin
            vs_q <= vsync_in;
            if (vs_rise) begin
                vcnt <= '0;
                vact <= 1'b1;
            end else if (hs_end && vact) begin
                if (vcnt == VW'(LINES - 1)) begin
                    vcnt <= '0;
                    vact <= 1'b0;
                end else begin
                    vcnt <= vcnt + 1'b1;
                end
            end
        end
    end

    assign vsync_out = vact && in_window(32'(vcnt), VS_ON, VS_OFF);
    assign vblank    = vact;

    assert_restart_R8: assert property (@(posedge clk) disable iff (rst)
        vs_rise |=> (vcnt == '0 && vact));
    assert_vcnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
        vcnt < VW'(LINES));
    assert_idle_count_R6: assert property (@(posedge clk) disable iff (rst)
        !vact |-> (vcnt == '0));

endmodule

// File: rtl/csb_sync_mix.sv
module csb_sync_mix
    import csb_pkg::*;
(
    input  logic hs_shaped,
    input  logic vs_shaped,
    input  logic hs_raw,
    input  logic vblank,
    output logic csync_n,
    output logic blank
);

    sync_pair_t pair;

    always_comb begin
        pair.hs = hs_shaped;
        pair.vs = vs_shaped;
        csync_n = merge_sync(pair);
        blank   = hs_raw || vblank;
    end

endmodule

// File: rtl/csb_gen.sv
module csb_gen
    import csb_pkg::*;
#(
    parameter int unsigned HS_ON  = HS_ON_DEF,
    parameter int unsigned HS_OFF = HS_OFF_DEF,
    parameter int unsigned VS_ON  = VS_ON_DEF,
    parameter int unsigned VS_OFF = VS_OFF_DEF,
    parameter int unsigned LINES  = VBLANK_DEF
) (
    input  logic clk,
    input  logic rst,
    input  logic char_en,
    input  logic hsync_in,
    input  logic vsync_in,
    output logic blank,
    output logic csync_n,
    output logic mode_strobe,
    output logic hsync_out,
    output logic vsync_out
);

    logic hs_end;
    logic vblank;

    csb_hcount #(.HS_ON(HS_ON), .HS_OFF(HS_OFF)) u_h (
        .clk(clk), .rst(rst), .char_en(char_en), .hsync_in(hsync_in),
        .hsync_out(hsync_out), .mode_strobe(mode_strobe), .hs_end(hs_end)
    );

    csb_vcount #(.VS_ON(VS_ON), .VS_OFF(VS_OFF), .LINES(LINES)) u_v (
        .clk(clk), .rst(rst), .char_en(char_en), .vsync_in(vsync_in),
        .hs_end(hs_end), .vsync_out(vsync_out), .vblank(vblank)
    );

    csb_sync_mix u_mix (
        .hs_shaped(hsync_out), .vs_shaped(vsync_out), .hs_raw(hsync_in),
        .vblank(vblank), .csync_n(csync_n), .blank(blank)
    );

    assert_hs_blank_R5: assert property (@(posedge clk) disable iff (rst)
        hsync_out |-> blank);
    assert_vs_blank_R7: assert property (@(posedge clk) disable iff (rst)
        vsync_out |-> blank);

endmodule

// File: tb/csb_gen_tb.sv
module csb_gen_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DIV        = 4;
    localparam int LINE_CHARS = 40;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic char_en = 1'b0, hsync_in = 1'b0, vsync_in = 1'b0;
    logic blank, csync_n, mode_strobe, hsync_out, vsync_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    string vtag = "R6 R7";

    // bench model state
    int m_h = 0, m_v = 0;
    bit m_vact = 0, m_vsq = 0, m_strobe = 0;
    int strobe_seen = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    csb_gen u_dut (
        .clk(clk), .rst(rst), .char_en(char_en), .hsync_in(hsync_in),
        .vsync_in(vsync_in), .blank(blank), .csync_n(csync_n),
        .mode_strobe(mode_strobe), .hsync_out(hsync_out), .vsync_out(vsync_out)
    );

    task automatic check(string what, string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic bit exp_hso(int h, bit hs);
        return hs && h >= 2 && h < 6;
    endfunction

    function automatic bit exp_vso(int v, bit act);
        return act && v >= 2 && v < 6;
    endfunction

    task automatic compare_all();
        bit hso, vso;
        hso = exp_hso(m_h, hsync_in);
        vso = exp_vso(m_v, m_vact);
        check("hsync_out", "R2 R3", hsync_out, hso);
        check("vsync_out", vtag, vsync_out, vso);
        check("blank", hsync_in ? "R5" : vtag, blank, hsync_in | m_vact);
        check("csync_n", "R9", csync_n, ~(hso ^ vso));
        check("mode_strobe", "R4", mode_strobe, m_strobe);
        if (mode_strobe) strobe_seen++;
    endtask

    task automatic model_step(bit ce, bit hs, bit vs);
        bit hs_end, rise;
        m_strobe = 0;
        if (ce) begin
            hs_end = (m_h != 0) && !hs;
            rise = vs && !m_vsq;
            m_strobe = hs && (m_h == 1);
            m_h = hs ? ((m_h < 6) ? m_h + 1 : 6) : 0;
            m_vsq = vs;
            if (rise) begin
                m_v = 0; m_vact = 1;
            end else if (hs_end && m_vact) begin
                m_v++;
                if (m_v == 26) begin m_vact = 0; m_v = 0; end
            end
        end
    endtask

    task automatic do_char(bit hs, bit vs);
        for (int i = 0; i < DIV; i++) begin
            @(negedge clk);
            char_en = (i == 0);
            hsync_in = hs;
            vsync_in = vs;
            #1;
            compare_all();
            @(posedge clk);
            model_step(char_en, hs, vs);
        end
    endtask

    task automatic do_line(int hs_start, int hs_w, bit vs);
        for (int c = 0; c < LINE_CHARS; c++)
            do_char((c >= hs_start) && (c < hs_start + hs_w), vs);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int w_list[6];
        int cnt;
        w_list = '{0, 1, 2, 5, 6, 14};
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("blank after reset", "R1", blank, 1'b0);
        check("csync_n after reset", "R1", csync_n, 1'b1);
        check("mode_strobe after reset", "R1", mode_strobe, 1'b0);
        check("hsync_out after reset", "R1", hsync_out, 1'b0);
        check("vsync_out after reset", "R1", vsync_out, 1'b0);

        // horizontal width sweep; R4 strobe count per line
        foreach (w_list[k]) begin
            strobe_seen = 0;
            do_line(20, w_list[k], 1'b0);
            check($sformatf("strobe present for width %0d", w_list[k]), "R4",
                  strobe_seen == 1, w_list[k] >= 2);
        end

        // short vertical pulse: blank for 26 lines (R7)
        do_line(20, 8, 1'b1);
        cnt = 1;
        while (m_vact && cnt < 40) begin do_line(20, 8, 1'b0); cnt++; end
        check("blank line count for one-line vsync", "R7", cnt == 26, 1'b1);

        // long vertical pulse: no restart while held, blank still ends (R7)
        for (int l = 0; l < 30; l++) do_line(20, 8, 1'b1);
        check("blank ended while vsync held", "R7", blank, 1'b0);
        do_line(20, 8, 1'b0);

        // restart inside window (R8)
        vtag = "R8";
        do_line(20, 8, 1'b1);
        for (int l = 0; l < 9; l++) do_line(20, 8, 1'b0);
        do_line(20, 8, 1'b1);
        cnt = 1;
        while (m_vact && cnt < 40) begin do_line(20, 8, 1'b0); cnt++; end
        check("window length after restart", "R8", cnt == 26, 1'b1);
        vtag = "R6 R7";

        // random lines
        for (int l = 0; l < 200; l++) begin
            int st, w;
            bit vs;
            st = 2 + int'($urandom_range(0, 20));
            w  = int'($urandom_range(0, 14));
            vs = ($urandom_range(0, 15) == 0) || (vsync_in && $urandom_range(0, 1) == 1);
            do_line(st, w, vs);
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule